// File: doc/BRIEF.md
# Sequenced Shift Buffer with Valid/Ready Channels

This block is a small queue built as a chain of byte places. Each place can hold one item. The places are numbered from the input end (place 0) to the output end (place N-1). The block works in rounds, and every round runs a fixed series of steps, one after another. First it offers the item in the output-end place on the output channel and waits for that transfer to finish. Next it copies places toward the output end, one place per clock, starting from the output end and moving back. Last it waits for an item on the input channel and stores it in place 0. Each round therefore uses N+1 sequential steps.

Every place resets to zero, and the output step comes first in a round. As a result, the first N items sent after reset are zero bytes. After them the input stream comes out in order, N items behind. A round counter gives the number of completed rounds, which is useful for throughput characterisation. Both channels use valid/ready handshakes: a transfer takes place on a rising clock edge when valid and ready are both high.

Top module: `ripple_reg`

## Requirements
- R1: While reset is held, and at release, out_valid is 1, in_ready is 0, out_data is 0x00 and round_cnt is 0.
- R2: The first N_PLACES items accepted on the output channel after reset are all 0x00.
- R3: Output item k (counting from 0) for k >= N_PLACES equals input item k-N_PLACES. Items keep their order and none is lost or duplicated.
- R4: out_valid and in_ready are never high in the same cycle. out_valid is high only in the send step, and in_ready is high only in the receive step.
- R5: When both channels are always willing, output transfers happen exactly N_PLACES+1 clocks apart.
- R6: While out_valid is high and out_ready is low, out_valid stays high, out_data holds its value and no input is accepted.
- R7: While in_ready is high and in_valid is low, in_ready stays high and out_valid stays low.
- R8: After an output transfer, both out_valid and in_ready are low for exactly N_PLACES-1 clocks (the copy steps). in_ready then rises, and after an input transfer out_valid is high in the next cycle.
- R9: round_cnt goes up by one, wrapping at 2^CNT_W, on each accepted input and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Producer offers in_data |
| in_ready | output | 1 | Block is in its receive step |
| in_data | input | DATA_W | Incoming item |
| out_valid | output | 1 | Block is in its send step |
| out_ready | input | 1 | Consumer accepts out_data |
| out_data | output | DATA_W | Content of the output-end place |
| round_cnt | output | CNT_W | Number of completed rounds, wrapping |

## Verification
The assertions check the handshake discipline on every cycle. These checks cover exclusive valid/ready phases, holding under back-pressure and under input starvation, the exact length of the copy window after each send, and the round counter stepping once per accepted input. Only the bench scenarios can show that data comes out right: the leading zero bytes, the delay of N items and the order of items under irregular valid/ready patterns. The same holds for the exact N+1 clock spacing when both sides are always ready.

// File: rtl/ripple_pkg.sv
package ripple_pkg;
  typedef enum logic [1:0] {
    PH_SEND = 2'd0,
    PH_COPY = 2'd1,
    PH_RECV = 2'd2
  } phase_e;
endpackage

// File: rtl/ripple_rst_sync.sv
module ripple_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ripple_seq.sv
module ripple_seq #(
  parameter int N_PLACES = 4,
  localparam int IW = (N_PLACES > 2) ? $clog2(N_PLACES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_ready,
  input  logic          in_valid,
  output logic          out_valid,
  output logic          in_ready,
  output logic          copy_go,
  output logic [IW-1:0] copy_idx,
  output logic          recv_fire
);
  import ripple_pkg::*;

  phase_e        phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    case (phase_q)
      PH_SEND: begin
        if (out_ready) begin
          phase_d = PH_COPY;
          idx_d   = IW'(N_PLACES - 1);
        end
      end
      PH_COPY: begin
        if (idx_q == IW'(1)) phase_d = PH_RECV;
        else                 idx_d   = idx_q - IW'(1);
      end
      PH_RECV: begin
        if (in_valid) phase_d = PH_SEND;
      end
      default: phase_d = PH_SEND;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SEND;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign out_valid = (phase_q == PH_SEND);
  assign in_ready  = (phase_q == PH_RECV);
  assign copy_go   = (phase_q == PH_COPY);
  assign copy_idx  = idx_q;
  assign recv_fire = in_ready & in_valid;
endmodule

// File: rtl/ripple_places.sv
module ripple_places #(
  parameter int N_PLACES = 4,
  parameter int DATA_W   = 8,
  localparam int IW = (N_PLACES > 2) ? $clog2(N_PLACES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recv_fire,
  input  logic [DATA_W-1:0] in_data,
  input  logic              copy_go,
  input  logic [IW-1:0]     copy_idx,
  output logic [DATA_W-1:0] tail_data
);
  logic [DATA_W-1:0] place_q [N_PLACES];
  logic [DATA_W-1:0] place_d [N_PLACES];
  logic              place_en [N_PLACES];

  for (genvar k = 0; k < N_PLACES; k++) begin : g_place
    if (k == 0) begin : g_head
      always_comb begin
        place_en[k] = recv_fire;
        place_d[k]  = in_data;
      end
    end else begin : g_body
      always_comb begin
        place_en[k] = copy_go && (copy_idx == IW'(k));
        place_d[k]  = place_q[k-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           place_q[k] <= '0;
      else if (place_en[k]) place_q[k] <= place_d[k];
    end
  end

  assign tail_data = place_q[N_PLACES-1];
endmodule

// File: rtl/ripple_round_cnt.sv
module ripple_round_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/ripple_reg.sv
module ripple_reg #(
  parameter int N_PLACES = 4,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  round_cnt
);
  localparam int IW = (N_PLACES > 2) ? $clog2(N_PLACES) : 1;

  logic          rst_sync_n;
  logic          copy_go;
  logic [IW-1:0] copy_idx;
  logic          recv_fire;

  ripple_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ripple_seq #(.N_PLACES(N_PLACES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .out_ready (out_ready),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .in_ready  (in_ready),
    .copy_go   (copy_go),
    .copy_idx  (copy_idx),
    .recv_fire (recv_fire)
  );

  ripple_places #(.N_PLACES(N_PLACES), .DATA_W(DATA_W)) u_places (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .recv_fire (recv_fire),
    .in_data   (in_data),
    .copy_go   (copy_go),
    .copy_idx  (copy_idx),
    .tail_data (out_data)
  );

  ripple_round_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (recv_fire),
    .count (round_cnt)
  );
endmodule

// File: rtl/ripple_reg_chk.sv
module ripple_reg_chk #(
  parameter int N_PLACES = 4,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  round_cnt
);
  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= '0;
    else if (!out_valid && !in_ready) gap_q <= gap_q + 8'd1;
    else                            gap_q <= '0;
  end

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));

  a_r6_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && !in_ready));

  a_r7_hold_in: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (in_ready && !out_valid));

  a_r8_after_send: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && !in_ready));

  a_r8_copy_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (gap_q == 8'(N_PLACES - 1)));

  a_r8_after_recv: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> out_valid);

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> (round_cnt == CNT_W'($past(round_cnt) + 1'b1)));

  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && in_valid) |=> $stable(round_cnt));
endmodule

bind ripple_reg ripple_reg_chk #(
  .N_PLACES (N_PLACES),
  .DATA_W   (DATA_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .round_cnt (round_cnt)
);

// File: tb/ripple_reg_tb.sv
module ripple_reg_tb;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  in_data;
  logic          out_valid;
  logic          out_ready;
  logic [W-1:0]  out_data;
  logic [CW-1:0] round_cnt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int in_n   = 0;
  int out_n  = 0;
  int last_fire = -1;
  bit last_fire_m0 = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] prev_data;
  bit prev_hold = 1'b0;

  always #4 clk = ~clk;

  ripple_reg #(.N_PLACES(N), .DATA_W(W), .CNT_W(CW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .round_cnt (round_cnt)
  );

  function automatic logic [W-1:0] item(int j);
    return W'((j * 37 + 11) & 255);
  endfunction

  function automatic logic [W-1:0] expect_out(int k);
    return (k < N) ? '0 : item(k - N);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // mode 0: both sides willing; 1: irregular; 2: output stalled; 3: input starved
  task automatic step(int mode);
    logic iv, ordy;
    bit fin, fout;
    @(negedge clk);
    cyc++;
    case (mode)
      0: begin iv = 1'b1; ordy = 1'b1; end
      1: begin iv = (cyc % 4 != 2); ordy = (cyc % 3 != 1); end
      2: begin iv = 1'b1; ordy = 1'b0; end
      default: begin iv = 1'b0; ordy = 1'b1; end
    endcase
    // R4: phases exclusive
    chk(!(out_valid && in_ready), "R4", int'(out_valid && in_ready), 0);
    // R9: counter tracks accepted inputs
    chk(round_cnt == CW'(in_n), "R9", int'(round_cnt), in_n & 16'hFFFF);
    // R6: held output while stalled
    if (prev_hold && out_valid)
      chk(out_data == prev_data, "R6", int'(out_data), int'(prev_data));
    prev_hold = out_valid && !ordy;
    prev_data = out_data;
    fout = out_valid && ordy;
    fin  = in_ready && iv;
    if (fout) begin
      if (out_n < N) chk(out_data == 8'h00, "R2", int'(out_data), 0);
      else           chk(out_data == expect_out(out_n), "R3", int'(out_data), int'(expect_out(out_n)));
      if (mode == 0 && last_fire_m0)
        chk(cyc - last_fire == N + 1, "R5", cyc - last_fire, N + 1);
      last_fire = cyc;
      last_fire_m0 = (mode == 0);
      out_n++;
    end
    if (mode != 0) last_fire_m0 = 1'b0;
    in_valid  = iv;
    out_ready = ordy;
    in_data   = item(in_n);
    if (fin) in_n++;
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) step(mode);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
    chk(in_ready == 1'b0, "R1", int'(in_ready), 0);
    chk(out_data == 8'h00, "R1", int'(out_data), 0);
    chk(round_cnt == '0, "R1", int'(round_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b1 && in_ready == 1'b0, "R1", int'({out_valid, in_ready}), 2);

    run(60, 0);
    run(200, 1);
    run(20, 2);
    // R6: after a long output stall the block waits in its send step
    chk(out_valid == 1'b1, "R6", int'(out_valid), 1);
    chk(in_ready == 1'b0, "R6", int'(in_ready), 0);
    chk(out_data == expect_out(out_n), "R6", int'(out_data), int'(expect_out(out_n)));
    run(30, 0);
    run(20, 3);
    // R7: after input starvation the block waits in its receive step
    chk(in_ready == 1'b1, "R7", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R7", int'(out_valid), 0);
    chk(round_cnt == CW'(in_n), "R7", int'(round_cnt), in_n);
    run(300, 1);
    run(50, 0);
    chk(out_n > 2 * N, "R3", out_n, 2 * N);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 700);
      summary();
      $finish;
    end
  end
endmodule